// File: doc/BRIEF.md
# DDR Power-Up and Refresh Sequencer

This block sits on the controller side of a DDR SDRAM interface. It takes the memory from power-up to a usable state, then keeps the stored contents alive with periodic auto-refresh. After reset it holds the clock enable low for a programmable power-up wait. It then raises the clock enable and issues a fixed start-up series: precharge-all, mode register write, precharge-all, and two auto-refresh commands. The spacing between these commands follows the precharge, mode-register and refresh recovery times. When the series is complete it raises a ready flag.

Once ready, a free-running interval counter adds one pending refresh each interval, and the request output stays high while any refresh is pending. The surrounding controller answers with a one-cycle grant. The sequencer then closes open rows with a precharge-all if the controller reports any open bank. It issues the refresh and keeps ready low for the refresh recovery time. A backlog of missed intervals is drained back to back under a single grant. Every delay is a parameter in clock cycles, so a simulation can use a short power-up wait. The mode register contents come from three configuration inputs: CAS latency, burst length and wrap order.

Top module: `ddr_init_refresh_seq`

## Requirements
- R1: While reset is asserted, cke_o is low, the command pins show deselect, and ready_o and ref_req_o are low.
- R2: cke_o rises exactly T_PWR clock edges after reset is released, and no command is issued while cke_o is low.
- R3: The start-up commands are, in order, precharge-all, mode register write, precharge-all, refresh, refresh. The first is issued one cycle after cke_o rises, and each later one follows its predecessor after T_RP, T_MRD, T_RP and T_RFC cycles respectively.
- R4: ready_o rises T_RFC cycles after the second start-up refresh, and no other command is issued during start-up.
- R5: Commands are encoded on {cs_no, ras_no, cas_no, we_no}. Deselect is 1111. Precharge-all is 0010 with addr_o[10] high. Mode register write is 0000 with ba_o = 00. Refresh is 0001. Every cycle without a command is deselect.
- R6: The mode register word on addr_o has these fields. Bits 2:0 hold the burst code: bl_sel_i 00 gives 001 (length 2), 01 gives 010 (length 4), and 10 or 11 give 011 (length 8). Bit 3 is wrap_ilv_i (1 selects interleaved). Bits 6:4 are 110 when cl_half_i is 1 (latency 2.5) and 010 otherwise (latency 2). All higher bits are zero.
- R7: ref_req_o first rises REF_INTERVAL cycles after ready_o first rises. An interval boundary falls every REF_INTERVAL cycles after that, and the request stays high until it is serviced.
- R8: A grant taken while a refresh is pending and bank_open_i is low produces a refresh in the next cycle. ready_o drops in that cycle and rises T_RFC cycles after the refresh.
- R9: A grant taken while a refresh is pending and bank_open_i is high produces a precharge-all in the next cycle, then a refresh T_RP cycles later, and ready_o rises T_RFC cycles after the refresh.
- R10: ready_o is low for the whole of a refresh service, and no command is issued while ready_o is high.
- R11: Pending refreshes saturate at MAX_PEND. A single grant drains all of them as refreshes spaced T_RFC apart, after which ref_req_o is low.
- R12: A grant while no refresh is pending is ignored: no command is issued and ready_o stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cl_half_i | input | 1 | 1 selects CAS latency 2.5, 0 selects 2 |
| bl_sel_i | input | 2 | Burst length select (00: 2, 01: 4, 1x: 8) |
| wrap_ilv_i | input | 1 | 1 selects interleaved wrap order |
| bank_open_i | input | 1 | Some bank holds an open row |
| ref_gnt_i | input | 1 | One-cycle grant for the pending refresh |
| cke_o | output | 1 | Clock enable to the memory |
| cs_no | output | 1 | Chip select, active low |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write enable, active low |
| ba_o | output | 2 | Bank address |
| addr_o | output | ADDR_W | Address / mode word |
| ready_o | output | 1 | Memory may take controller traffic |
| ref_req_o | output | 1 | At least one refresh is pending |

## Verification
A state register stuck or skipping a step shows at the command pins within one recovery window. It appears as a missing, repeated or misordered command in the start-up series, or as ready_o rising at the wrong edge. A miscount in the shared delay counter shifts a command by a cycle, which shows up as a spacing error on the next command. A fault in the interval or pending counters surfaces only after one or more refresh intervals. It appears as a request edge off its expected cycle, or as a drained burst of the wrong length, so these checks run across several intervals and a saturated backlog.

// File: rtl/ddr_seq_pkg.sv
package ddr_seq_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_DESEL  = 4'b1111,
    CMD_PREALL = 4'b0010,
    CMD_MRS    = 4'b0000,
    CMD_REF    = 4'b0001
  } cmd_e;

  typedef enum logic [3:0] {
    ST_PWR, ST_PRE1, ST_MRS, ST_PRE2, ST_REF1, ST_REF2,
    ST_INITW, ST_IDLE, ST_RREF, ST_RWAIT
  } seq_st_e;

  function automatic logic [6:0] mode_word(input logic [1:0] bl_sel,
                                           input logic wrap_ilv,
                                           input logic cl_half);
    logic [2:0] bl;
    case (bl_sel)
      2'b00:   bl = 3'b001;
      2'b01:   bl = 3'b010;
      default: bl = 3'b011;
    endcase
    return {cl_half ? 3'b110 : 3'b010, wrap_ilv, bl};
  endfunction
endpackage

// File: rtl/ddr_seq_delay.sv
module ddr_seq_delay #(
  parameter int W       = 8,
  parameter int RST_VAL = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= W'(RST_VAL);
    else if (load_i)       cnt_q <= val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/ddr_seq_ref_track.sv
module ddr_seq_ref_track #(
  parameter int INTERVAL = 2080,
  parameter int MAX_PEND = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic dec_i,
  output logic req_o
);
  localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam int PW = $clog2(MAX_PEND + 1);

  logic [CW-1:0] cnt_q;
  logic [PW-1:0] pend_q;
  logic          tick;

  assign tick = en_i && (cnt_q == CW'(INTERVAL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else if (en_i) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else begin
      case ({tick, dec_i})
        2'b10:   if (pend_q != PW'(MAX_PEND)) pend_q <= pend_q + 1'b1;
        2'b01:   pend_q <= pend_q - 1'b1;
        default: ;
      endcase
    end
  end

  assign req_o = (pend_q != '0);
endmodule

// File: rtl/ddr_init_refresh_seq.sv
module ddr_init_refresh_seq
  import ddr_seq_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int T_PWR        = 133400,
  parameter int T_RP         = 3,
  parameter int T_MRD        = 2,
  parameter int T_RFC        = 10,
  parameter int REF_INTERVAL = 2080,
  parameter int MAX_PEND     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cl_half_i,
  input  logic [1:0]        bl_sel_i,
  input  logic              wrap_ilv_i,
  input  logic              bank_open_i,
  input  logic              ref_gnt_i,
  output logic              cke_o,
  output logic              cs_no,
  output logic              ras_no,
  output logic              cas_no,
  output logic              we_no,
  output logic [1:0]        ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              ready_o,
  output logic              ref_req_o
);
  localparam int M1    = (T_RP > T_MRD) ? T_RP : T_MRD;
  localparam int M2    = (M1 > T_RFC) ? M1 : T_RFC;
  localparam int MAXD  = (M2 > T_PWR) ? M2 : T_PWR;
  localparam int DLY_W = $clog2(MAXD + 1);

  seq_st_e           st_q, st_n;
  cmd_e              cmd_q, cmd_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic              cke_q, cke_n, rdy_q, rdy_n, done_q, done_n;
  logic              dly_ld, dly_zero, ref_dec, req;
  logic [DLY_W-1:0]  dly_val;

  ddr_seq_delay #(.W(DLY_W), .RST_VAL(T_PWR - 1)) u_dly (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(dly_ld), .val_i(dly_val), .zero_o(dly_zero)
  );

  ddr_seq_ref_track #(.INTERVAL(REF_INTERVAL), .MAX_PEND(MAX_PEND)) u_trk (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(done_q), .dec_i(ref_dec), .req_o(req)
  );

  always_comb begin
    st_n    = st_q;
    cmd_n   = CMD_DESEL;
    addr_n  = '0;
    cke_n   = cke_q;
    rdy_n   = rdy_q;
    done_n  = done_q;
    dly_ld  = 1'b0;
    dly_val = '0;
    ref_dec = 1'b0;
    case (st_q)
      ST_PWR: if (dly_zero) begin
        cke_n = 1'b1;
        st_n  = ST_PRE1;
      end
      ST_PRE1: if (dly_zero) begin
        cmd_n = CMD_PREALL; addr_n[10] = 1'b1;
        dly_ld = 1'b1; dly_val = DLY_W'(T_RP - 1);
        st_n = ST_MRS;
      end
      ST_MRS: if (dly_zero) begin
        cmd_n = CMD_MRS; addr_n[6:0] = mode_word(bl_sel_i, wrap_ilv_i, cl_half_i);
        dly_ld = 1'b1; dly_val = DLY_W'(T_MRD - 1);
        st_n = ST_PRE2;
      end
      ST_PRE2: if (dly_zero) begin
        cmd_n = CMD_PREALL; addr_n[10] = 1'b1;
        dly_ld = 1'b1; dly_val = DLY_W'(T_RP - 1);
        st_n = ST_REF1;
      end
      ST_REF1, ST_REF2: if (dly_zero) begin
        cmd_n = CMD_REF;
        dly_ld = 1'b1; dly_val = DLY_W'(T_RFC - 1);
        st_n = (st_q == ST_REF1) ? ST_REF2 : ST_INITW;
      end
      ST_INITW: if (dly_zero) begin
        rdy_n = 1'b1; done_n = 1'b1;
        st_n = ST_IDLE;
      end
      ST_IDLE: if (ref_gnt_i && req) begin
        rdy_n = 1'b0;
        dly_ld = 1'b1;
        if (bank_open_i) begin
          cmd_n = CMD_PREALL; addr_n[10] = 1'b1;
          dly_val = DLY_W'(T_RP - 1);
          st_n = ST_RREF;
        end else begin
          cmd_n = CMD_REF; ref_dec = 1'b1;
          dly_val = DLY_W'(T_RFC - 1);
          st_n = ST_RWAIT;
        end
      end
      ST_RREF: if (dly_zero) begin
        cmd_n = CMD_REF; ref_dec = 1'b1;
        dly_ld = 1'b1; dly_val = DLY_W'(T_RFC - 1);
        st_n = ST_RWAIT;
      end
      ST_RWAIT: if (dly_zero) begin
        // drain backlog without a new grant
        if (req) begin
          cmd_n = CMD_REF; ref_dec = 1'b1;
          dly_ld = 1'b1; dly_val = DLY_W'(T_RFC - 1);
        end else begin
          rdy_n = 1'b1;
          st_n = ST_IDLE;
        end
      end
      default: st_n = ST_PWR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_PWR;
      cmd_q  <= CMD_DESEL;
      addr_q <= '0;
      cke_q  <= 1'b0;
      rdy_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      cmd_q  <= cmd_n;
      addr_q <= addr_n;
      cke_q  <= cke_n;
      rdy_q  <= rdy_n;
      done_q <= done_n;
    end
  end

  assign {cs_no, ras_no, cas_no, we_no} = cmd_q;
  assign ba_o      = 2'b00;
  assign addr_o    = addr_q;
  assign cke_o     = cke_q;
  assign ready_o   = rdy_q;
  assign ref_req_o = req;
endmodule

// File: rtl/ddr_init_refresh_seq_chk.sv
module ddr_init_refresh_seq_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wrap_ilv_i,
  input logic              ref_gnt_i,
  input logic              cke_o,
  input logic              cs_no,
  input logic              ras_no,
  input logic              cas_no,
  input logic              we_no,
  input logic [1:0]        ba_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              ready_o,
  input logic              ref_req_o
);
  logic is_pre, is_mrs;
  assign is_pre = !cs_no && !ras_no && cas_no && !we_no;
  assign is_mrs = !cs_no && !ras_no && !cas_no && !we_no;

  // R2
  cke_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_o |-> cs_no);

  // R5
  pre_a10_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_pre |-> addr_o[10]);

  // R6
  mrs_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_mrs |-> (ba_o == 2'b00 && addr_o[ADDR_W-1:7] == '0 && addr_o[3] == wrap_ilv_i
                && addr_o[5:4] == 2'b10 && addr_o[2:0] != 3'b000 && !addr_o[2]));

  // R10
  ready_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> cs_no);

  // R7
  req_after_init_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_req_o |-> cke_o);

  // R12
  idle_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && ref_gnt_i && !ref_req_o) |=> (cs_no && ready_o));
endmodule

bind ddr_init_refresh_seq ddr_init_refresh_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wrap_ilv_i(wrap_ilv_i), .ref_gnt_i(ref_gnt_i),
  .cke_o(cke_o), .cs_no(cs_no), .ras_no(ras_no), .cas_no(cas_no), .we_no(we_no),
  .ba_o(ba_o), .addr_o(addr_o), .ready_o(ready_o), .ref_req_o(ref_req_o)
);

// File: tb/ddr_init_refresh_seq_tb.sv
module ddr_init_refresh_seq_tb;
  localparam int AW = 12, TPW = 20, TRP = 3, TMR = 2, TRF = 6, IV = 100, MP = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cl_half = 1'b0, wrap = 1'b0, bank_open = 1'b0, gnt = 1'b0;
  logic [1:0] bl_sel = 2'b00;
  logic cke, cs_n, ras_n, cas_n, we_n, rdy, req;
  logic [1:0] ba;
  logic [AW-1:0] addr;

  ddr_init_refresh_seq #(.ADDR_W(AW), .T_PWR(TPW), .T_RP(TRP), .T_MRD(TMR), .T_RFC(TRF),
                         .REF_INTERVAL(IV), .MAX_PEND(MP)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cl_half_i(cl_half), .bl_sel_i(bl_sel),
    .wrap_ilv_i(wrap), .bank_open_i(bank_open), .ref_gnt_i(gnt),
    .cke_o(cke), .cs_no(cs_n), .ras_no(ras_n), .cas_no(cas_n), .we_no(we_n),
    .ba_o(ba), .addr_o(addr), .ready_o(rdy), .ref_req_o(req)
  );

  always #10 clk = ~clk;

  int cyc;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  // command log: 1 precharge-all, 2 mode write, 3 refresh, 4 other
  int n_cmd, stray, cke_rise, rdy_rise;
  int lg_kind [64];
  int lg_cyc  [64];
  int lg_addr [64];
  int lg_ba   [64];
  logic prev_cke, prev_rdy;

  always @(negedge clk) begin
    if (!rst_n) begin
      n_cmd = 0; cke_rise = -1; rdy_rise = -1; prev_cke = 1'b0; prev_rdy = 1'b0;
    end else begin
      if (cke && !prev_cke) cke_rise = cyc;
      if (rdy && !prev_rdy) rdy_rise = cyc;
      prev_cke = cke; prev_rdy = rdy;
      if (!cs_n) begin
        if (n_cmd < 64) begin
          case ({ras_n, cas_n, we_n})
            3'b010:  lg_kind[n_cmd] = 1;
            3'b000:  lg_kind[n_cmd] = 2;
            3'b001:  lg_kind[n_cmd] = 3;
            default: lg_kind[n_cmd] = 4;
          endcase
          lg_cyc[n_cmd] = cyc; lg_addr[n_cmd] = int'(addr); lg_ba[n_cmd] = int'(ba);
        end
        n_cmd = n_cmd + 1;
      end else if (!(ras_n && cas_n && we_n)) stray = stray + 1;
    end
  end

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string req_tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req_tag, what, act, exp);
    end
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) begin @(posedge clk); #2; end
  endtask

  task automatic pulse_gnt(input logic open);
    gnt = 1'b1; bank_open = open;
    @(posedge clk); #2;
    gnt = 1'b0; bank_open = 1'b0;
  endtask

  task automatic run_init(input int bs, input int wr, input int cl, input bit first);
    int e0, e1, e2, e3, e4, er, mw;
    bl_sel = 2'(bs); wrap = wr[0]; cl_half = cl[0];
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    if (first) begin
      chk("R1", "cke in reset", int'(cke), 0);
      chk("R1", "cs_n in reset", int'(cs_n), 1);
      chk("R1", "ready in reset", int'(rdy), 0);
      chk("R1", "req in reset", int'(req), 0);
    end
    rst_n = 1'b1;
    e0 = TPW + 1; e1 = e0 + TRP; e2 = e1 + TMR; e3 = e2 + TRP; e4 = e3 + TRF; er = e4 + TRF;
    wait_until(er + 3);
    mw = ((cl != 0 ? 6 : 2) << 4) | (wr << 3) | (bs == 0 ? 1 : (bs == 1 ? 2 : 3));
    chk("R2", "cke rise cycle", cke_rise, TPW);
    chk("R4", "init command count", n_cmd, 5);
    chk("R3", "cmd0 kind", lg_kind[0], 1); chk("R3", "cmd0 cycle", lg_cyc[0], e0);
    chk("R3", "cmd1 kind", lg_kind[1], 2); chk("R3", "cmd1 cycle", lg_cyc[1], e1);
    chk("R3", "cmd2 kind", lg_kind[2], 1); chk("R3", "cmd2 cycle", lg_cyc[2], e2);
    chk("R3", "cmd3 kind", lg_kind[3], 3); chk("R3", "cmd3 cycle", lg_cyc[3], e3);
    chk("R3", "cmd4 kind", lg_kind[4], 3); chk("R3", "cmd4 cycle", lg_cyc[4], e4);
    chk("R5", "precharge a10", (lg_addr[0] >> 10) & 1, 1);
    chk("R5", "mode bank", lg_ba[1], 0);
    chk("R6", "mode word", lg_addr[1], mw);
    chk("R4", "ready rise cycle", rdy_rise, er);
  endtask

  initial begin
    int r, t, n0;
    stray = 0;
    for (int bs = 0; bs < 4; bs++)
      for (int wr = 0; wr < 2; wr++)
        for (int cl = 0; cl < 2; cl++)
          run_init(bs, wr, cl, (bs == 0 && wr == 0 && cl == 0));

    r = rdy_rise;
    n0 = n_cmd;
    // R12 grant with nothing pending
    wait_until(r + 5);
    pulse_gnt(1'b0);
    wait_until(r + 10);
    chk("R12", "commands after idle grant", n_cmd, n0);
    chk("R12", "ready after idle grant", int'(rdy), 1);

    // R7 request timing
    wait_until(r + IV - 1);
    chk("R7", "req before interval", int'(req), 0);
    wait_until(r + IV);
    chk("R7", "req at interval", int'(req), 1);
    wait_until(r + IV + 20);
    chk("R7", "req held until grant", int'(req), 1);

    // R8 refresh with banks closed
    t = cyc;
    pulse_gnt(1'b0);
    chk("R10", "ready low at refresh", int'(rdy), 0);
    chk("R8", "req cleared", int'(req), 0);
    wait_until(t + TRF);
    chk("R10", "ready low in recovery", int'(rdy), 0);
    wait_until(t + TRF + 2);
    chk("R8", "refresh count", n_cmd, n0 + 1);
    chk("R8", "refresh kind", lg_kind[n0], 3);
    chk("R8", "refresh cycle", lg_cyc[n0], t + 1);
    chk("R8", "ready return", rdy_rise, t + 1 + TRF);

    // R9 refresh with a bank open
    wait_until(r + 2 * IV);
    chk("R7", "second interval req", int'(req), 1);
    t = cyc;
    pulse_gnt(1'b1);
    wait_until(t + TRP + TRF + 3);
    chk("R9", "command count", n_cmd, n0 + 3);
    chk("R9", "precharge kind", lg_kind[n0 + 1], 1);
    chk("R9", "precharge cycle", lg_cyc[n0 + 1], t + 1);
    chk("R9", "refresh kind", lg_kind[n0 + 2], 3);
    chk("R9", "refresh cycle", lg_cyc[n0 + 2], t + 1 + TRP);
    chk("R9", "ready return", rdy_rise, t + 1 + TRP + TRF);

    // R11 backlog of ten intervals saturates at MP
    wait_until(r + 12 * IV);
    chk("R11", "req with backlog", int'(req), 1);
    t = cyc;
    n0 = n_cmd;
    pulse_gnt(1'b0);
    wait_until(t + 1 + 3 * TRF);
    chk("R10", "ready low mid burst", int'(rdy), 0);
    wait_until(t + IV - 5);
    chk("R11", "burst length", n_cmd - n0, MP);
    for (int k = 0; k < MP; k++) begin
      chk("R11", "burst kind", lg_kind[n0 + k], 3);
      chk("R11", "burst cycle", lg_cyc[n0 + k], t + 1 + k * TRF);
    end
    chk("R11", "ready after burst", rdy_rise, t + 1 + MP * TRF);
    chk("R11", "req after burst", int'(req), 0);
    chk("R5", "non-deselect idle cycles", stray, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R3 watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule